// File: doc/BRIEF.md
# Dual-Policy Direct-Mapped Data Cache

This block is a first-level data cache placed between a processor's load/store port and a next-level memory port. It is direct-mapped, with a line size and a capacity set by parameters. A 64-byte line and a 32 KB array are the intended full-size build. The defaults are kept small so that elaboration stays light. The tag array, the valid and dirty state and the data array serve both write policies. A static input, `cfg_write_through`, chooses between them.

With `cfg_write_through` low, the cache allocates on writes and writes back. A store miss brings the line in. A store hit changes only the local copy and marks the line dirty. Modified data leaves the cache only when a dirty line is displaced. With `cfg_write_through` high, the cache writes through and never allocates on a store. Every store is placed in a small FIFO of single-word writes, and the FIFO drains to the next level while hits continue. A store that finds the FIFO full holds the processor. A load miss is not serviced until the FIFO is empty, so a fill never returns data older than a pending store.

`cfg_write_through` may change only while reset is applied. The processor holds `cpu_valid`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until `cpu_done` is seen. Addresses on both ports are word addresses. A next-level beat transfers in any cycle in which `mem_req` and `mem_ready` are both high. A line transfer is one beat per word, at ascending word addresses from the line base.

Top module: `wpc_dcache`

## Requirements
- R1: After reset every line is invalid and the store FIFO is empty. `mem_req` is low, and no access completes while `cpu_valid` is low.
- R2: A load or store that hits asserts `cpu_done` in the same cycle it is presented, with `cpu_stall` low. A load returns the stored word on `cpu_rdata`.
- R3: A load miss, or a store miss with `cfg_write_through`=0, reads the whole line as one beat per word, at ascending word addresses from the line base (`mem_we`=0). The access completes in the cycle after the last read beat is accepted. While `mem_ready` is low, `mem_req` and its address stay unchanged.
- R4: With `cfg_write_through`=0, a store hit updates only the cached word and makes no next-level transfer. A store miss allocates the line through a fill before it completes.
- R5: With `cfg_write_through`=0, a miss whose victim is valid and dirty first writes every word of the victim to the victim's address (`mem_we`=1, ascending). Only then does the first read beat of the fill appear. A freshly filled line is clean, so displacing it later writes nothing back.
- R6: With `cfg_write_through`=1, every store completes by queuing exactly one single-word write (`mem_we`=1) of that word. A store miss allocates nothing, and lines never become dirty, so no write-back occurs.
- R7: With `cfg_write_through`=1, a store hit also updates the cached word, and a following load hits with the new value.
- R8: The store FIFO holds `WB_DEPTH` (default 8) stores. Once it is full, a write-through store stalls until an entry has been sent to the next level.
- R9: A load miss produces no read beat while the store FIFO holds entries. The load then returns the value of the most recent buffered store to that word.
- R10: Buffered stores go to the next level in issue order, one beat each, while the cache keeps serving hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_write_through | input | 1 | 0: allocate on write, write back; 1: no allocate, write through |
| cpu_valid | input | 1 | Processor access present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W-2 | Word address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Access present but not completing |
| mem_req | output | 1 | Next-level beat request |
| mem_we | output | 1 | Beat direction, 1 = write |
| mem_addr | output | ADDR_W-2 | Word address of the current beat |
| mem_wdata | output | DATA_W | Write beat data |
| mem_ready | input | 1 | Next level accepts or supplies the beat this cycle |
| mem_rdata | input | DATA_W | Read beat data, valid with `mem_ready` |

## Verification
Hits are due in the very cycle they are presented, so the bench presents each access half a cycle before an edge and looks for `cpu_done` before that edge. It also counts the edges the access waits: one for a hit, and more than the blocking window for a store into a full FIFO. A miss must finish exactly one cycle after the last accepted read beat. The bench records the cycle of every beat it grants and compares that with the cycle of `cpu_done`. Every next-level beat is checked against a queue of expected beats (direction, address, data), filled ahead of each access in the order the requirements impose. Misordering, an extra beat or a missing beat is therefore caught at the beat itself or by the final queue check.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } ctl_state_e;

    typedef enum logic {
        POL_WRITE_BACK    = 1'b0,
        POL_WRITE_THROUGH = 1'b1
    } policy_e;

    function automatic int words_per_line(input int line_bytes, input int data_w);
        return (line_bytes * 8) / data_w;
    endfunction

endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 4,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_set,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [LINES-1:0] vld;
    logic [LINES-1:0] drt;
    logic [TAG_W-1:0] tags [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            drt <= '0;
        end else if (fill_en) begin
            vld[idx]  <= 1'b1;
            drt[idx]  <= 1'b0;
            tags[idx] <= fill_tag;
        end else if (dirty_set) begin
            drt[idx] <= 1'b1;
        end
    end

    assign line_valid = vld[idx];
    assign line_dirty = drt[idx];
    assign line_tag   = tags[idx];

    // A line can only be marked dirty after it has been filled
    p_dirty_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
        dirty_set |-> line_valid);
endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(LINES) + $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] cells [LINES*WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/wpc_store_fifo.sv
module wpc_store_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                slots[wp] <= din;
                wp        <= bump(wp);
            end
            if (pop) rp <= bump(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    assign head  = slots[rp];
    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/wpc_dcache.sv
module wpc_dcache
    import wpc_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int CACHE_BYTES = 1024,
    parameter int WB_DEPTH    = 8,
    localparam int BOFS_W     = $clog2(DATA_W / 8),
    localparam int WADDR_W    = ADDR_W - BOFS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_write_through,
    input  logic               cpu_valid,
    input  logic               cpu_we,
    input  logic [WADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_done,
    output logic               cpu_stall,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ready,
    input  logic [DATA_W-1:0]  mem_rdata
);
    localparam int WORDS  = words_per_line(LINE_BYTES, DATA_W);
    localparam int WOFS_W = $clog2(WORDS);
    localparam int LINES  = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = WADDR_W - IDX_W - WOFS_W;

    typedef struct packed {
        logic [WADDR_W-1:0] addr;
        logic [DATA_W-1:0]  data;
    } wb_item_t;

    // request decode
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WOFS_W-1:0] req_word;
    assign {req_tag, req_idx, req_word} = cpu_addr;

    policy_e pol;
    assign pol = policy_e'(cfg_write_through);

    // line state
    logic             line_valid, line_dirty;
    logic [TAG_W-1:0] line_tag;
    logic             hit;
    logic             fill_done, dirty_set;

    wpc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .idx        (req_idx),
        .fill_en    (fill_done),
        .fill_tag   (req_tag),
        .dirty_set  (dirty_set),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag)
    );

    assign hit = line_valid && (line_tag == req_tag);

    // data array
    logic              arr_we;
    logic [WOFS_W-1:0] arr_word;
    logic [DATA_W-1:0] arr_wdata;
    logic [DATA_W-1:0] evict_word;
    logic [WOFS_W-1:0] beat, beat_nxt;

    wpc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .we      (arr_we),
        .waddr   ({req_idx, arr_word}),
        .wdata   (arr_wdata),
        .raddr_a ({req_idx, req_word}),
        .rdata_a (cpu_rdata),
        .raddr_b ({req_idx, beat}),
        .rdata_b (evict_word)
    );

    // store FIFO for the write-through policy
    wb_item_t wb_in, wb_head;
    logic     wb_push, wb_pop, wb_full, wb_empty;

    assign wb_in = '{addr: cpu_addr, data: cpu_wdata};

    wpc_store_fifo #(.DEPTH(WB_DEPTH), .W($bits(wb_item_t))) u_wbuf (
        .clk   (clk),
        .rst   (rst),
        .push  (wb_push),
        .pop   (wb_pop),
        .din   (wb_in),
        .head  (wb_head),
        .full  (wb_full),
        .empty (wb_empty)
    );

    // controller
    ctl_state_e state, state_nxt;
    logic       last_beat;
    assign last_beat = (beat == WOFS_W'(WORDS - 1));

    always_comb begin
        state_nxt = state;
        beat_nxt  = beat;
        cpu_done  = 1'b0;
        arr_we    = 1'b0;
        arr_word  = req_word;
        arr_wdata = cpu_wdata;
        dirty_set = 1'b0;
        fill_done = 1'b0;
        wb_push   = 1'b0;
        wb_pop    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_IDLE: begin
                if (!wb_empty) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = wb_head.addr;
                    mem_wdata = wb_head.data;
                    wb_pop    = mem_ready;
                end
                if (cpu_valid) begin
                    if (cpu_we && pol == POL_WRITE_THROUGH) begin
                        if (!wb_full) begin
                            cpu_done = 1'b1;
                            wb_push  = 1'b1;
                            arr_we   = hit;
                        end
                    end else if (hit) begin
                        cpu_done  = 1'b1;
                        arr_we    = cpu_we;
                        dirty_set = cpu_we;
                    end else if (wb_empty) begin
                        beat_nxt  = '0;
                        state_nxt = (line_valid && line_dirty) ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {line_tag, req_idx, beat};
                mem_wdata = evict_word;
                if (mem_ready) begin
                    beat_nxt = beat + 1'b1;
                    if (last_beat) state_nxt = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag, req_idx, beat};
                if (mem_ready) begin
                    arr_we    = 1'b1;
                    arr_word  = beat;
                    arr_wdata = mem_rdata;
                    beat_nxt  = beat + 1'b1;
                    if (last_beat) begin
                        fill_done = 1'b1;
                        state_nxt = ST_IDLE;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= state_nxt;
            beat  <= beat_nxt;
        end
    end

    assign cpu_stall = cpu_valid && !cpu_done;

    // a pending beat keeps its request, address and direction
    p_hold_req_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // allocate-on-write policy writes to the next level only while evicting
    p_wb_writes_evict_r4: assert property (@(posedge clk) disable iff (rst)
        (pol == POL_WRITE_BACK && mem_req && mem_we) |-> (state == ST_EVICT));
    // a just-filled line is present and clean for the held access
    p_fill_clean_r5: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> (hit && !line_dirty));
    // write-through never leaves a dirty line
    p_wt_never_dirty_r6: assert property (@(posedge clk) disable iff (rst)
        (pol == POL_WRITE_THROUGH) |-> !(line_valid && line_dirty));
    // a completed write-through store leaves something queued
    p_wt_store_queued_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && cpu_we && pol == POL_WRITE_THROUGH) |=> !wb_empty);
    // full FIFO blocks a write-through store
    p_full_stalls_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_we && pol == POL_WRITE_THROUGH && wb_full) |-> cpu_stall);
    // line transfers only start after the FIFO has drained
    p_fill_after_drain_r9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> wb_empty);
endmodule

// File: tb/sim_wpc_dcache.sv
module sim_wpc_dcache;
    localparam int ADDR_W  = 14;
    localparam int DATA_W  = 32;
    localparam int WADDR_W = ADDR_W - 2;
    localparam int WORDS   = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_wt = 1'b0;
    logic               cpu_valid = 1'b0;
    logic               cpu_we = 1'b0;
    logic [WADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0]  cpu_wdata = '0;
    logic [DATA_W-1:0]  cpu_rdata;
    logic               cpu_done, cpu_stall;
    logic               mem_req, mem_we;
    logic [WADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0]  mem_wdata;
    logic               mem_ready = 1'b0;
    logic [DATA_W-1:0]  mem_rdata = '0;

    wpc_dcache u0 (
        .clk(clk), .rst(rst), .cfg_write_through(cfg_wt),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;   // 100 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // memory contents: next level and processor-visible reference
    logic [DATA_W-1:0] pmem [int];
    logic [DATA_W-1:0] shadow [int];

    function automatic logic [DATA_W-1:0] seed(input int a);
        return (DATA_W'(a) * 32'h0001_0003) ^ 32'hA500_0000;
    endfunction
    function automatic logic [DATA_W-1:0] rd_p(input int a);
        return pmem.exists(a) ? pmem[a] : seed(a);
    endfunction
    function automatic logic [DATA_W-1:0] rd_s(input int a);
        return shadow.exists(a) ? shadow[a] : seed(a);
    endfunction

    // scoreboard queues
    typedef struct { bit we; int addr; logic [31:0] data; int rq; } mx_t;
    typedef struct { logic [31:0] data; int rq; } rx_t;
    mx_t mem_q[$];
    rx_t rd_q[$];

    task automatic exp_beat(input bit we, input int addr, input logic [31:0] d, input int rq);
        mx_t e;
        e.we = we; e.addr = addr; e.data = d; e.rq = rq;
        mem_q.push_back(e);
    endtask
    task automatic exp_fill(input int base, input int rq);
        for (int i = 0; i < WORDS; i++) exp_beat(1'b0, base + i, '0, rq);
    endtask
    task automatic exp_evict(input int base, input int rq);
        for (int i = 0; i < WORDS; i++) exp_beat(1'b1, base + i, rd_s(base + i), rq);
    endtask

    // next-level responder and beat monitor
    int lat = 2;
    int lat_cnt = 0;
    bit hold = 1'b0;
    int n_xfer = 0;
    int last_grant = 0;

    always @(negedge clk) begin
        #1;
        if (mem_req === 1'b1 && !hold && lat_cnt >= lat) begin
            mem_ready  = 1'b1;
            mem_rdata  = rd_p(int'(mem_addr));
            n_xfer++;
            last_grant = cyc;
            lat_cnt    = 0;
            if (mem_we) pmem[int'(mem_addr)] = mem_wdata;
            if (mem_q.size() == 0) begin
                chk(1'b0, 0, "unexpected next-level beat", {20'd0, mem_addr}, 32'hFFFF_FFFF);
            end else begin
                mx_t e;
                e = mem_q.pop_front();
                chk((e.we == mem_we) && (e.addr == int'(mem_addr)) &&
                    (!e.we || e.data == mem_wdata), e.rq,
                    mem_we ? "write beat addr/data" : "read beat addr",
                    mem_we ? mem_wdata : {20'd0, mem_addr},
                    e.we ? e.data : e.addr);
            end
        end else begin
            mem_ready = 1'b0;
            if (mem_req === 1'b1) lat_cnt++;
        end
    end

    // processor-side monitor
    bit acc_seen = 1'b0;
    int done_cyc = 0;
    always @(negedge clk) begin
        #2;
        acc_seen = (cpu_valid === 1'b1) && (cpu_done === 1'b1);
        if (acc_seen) begin
            done_cyc = cyc;
            if (!cpu_we) begin
                if (rd_q.size() == 0) begin
                    chk(1'b0, 2, "unexpected load completion", cpu_rdata, 32'hFFFF_FFFF);
                end else begin
                    rx_t r;
                    r = rd_q.pop_front();
                    chk(cpu_rdata == r.data, r.rq, "load data", cpu_rdata, r.data);
                end
            end
        end
    end

    // driver
    task automatic op(input bit we, input int addr, input logic [31:0] wd,
                      input int rq, output int waited);
        rx_t r;
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_we    = we;
        cpu_addr  = WADDR_W'(addr);
        cpu_wdata = wd;
        if (!we) begin
            r.data = rd_s(addr); r.rq = rq;
            rd_q.push_back(r);
        end else begin
            shadow[addr] = wd;
        end
        waited = 0;
        do begin
            @(posedge clk);
            waited++;
        end while (!acc_seen && waited < 3000);
        if (!acc_seen) chk(1'b0, rq, "access never completed", 32'(waited), 32'd0);
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic do_reset(input bit wt);
        @(negedge clk);
        rst = 1'b1;
        cfg_wt = wt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 400 && mem_q.size() != 0; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #1_500_000;
        n_cmp++;
        n_bad++;
        $display("FAIL R0 watchdog expired: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int w;
        int xs;
        do_reset(1'b0);
        @(negedge clk);
        #3;
        // R1: idle after reset
        chk(mem_req == 1'b0, 1, "mem_req after reset", {31'd0, mem_req}, 32'd0);
        chk(cpu_done == 1'b0 && cpu_stall == 1'b0, 1, "done/stall with no access",
            {30'd0, cpu_done, cpu_stall}, 32'd0);

        // R3: load miss fills the line at ascending word addresses
        exp_fill(32'h010, 3);
        op(1'b0, 32'h011, '0, 3, w);
        chk(done_cyc - last_grant == 1, 3, "miss completion one cycle after last beat",
            32'(done_cyc - last_grant), 32'd1);

        // R2: hit completes in the presented cycle
        op(1'b0, 32'h012, '0, 2, w);
        chk(w == 1, 2, "load hit wait cycles", 32'(w), 32'd1);

        // R4: store hit stays local
        xs = n_xfer;
        op(1'b1, 32'h013, 32'hD00D_0001, 4, w);
        chk(w == 1, 2, "store hit wait cycles", 32'(w), 32'd1);
        op(1'b0, 32'h013, '0, 4, w);
        chk(n_xfer == xs, 4, "next-level beats after store hit", 32'(n_xfer - xs), 32'd0);

        // R4: store miss allocates
        exp_fill(32'h040, 4);
        op(1'b1, 32'h045, 32'hD00D_0002, 4, w);
        op(1'b0, 32'h045, '0, 4, w);
        chk(w == 1, 4, "load after allocating store hits", 32'(w), 32'd1);

        // R5: dirty victim written back before the new line is read
        exp_evict(32'h010, 5);
        exp_fill(32'h110, 5);
        op(1'b0, 32'h110, '0, 5, w);
        // R5: clean victim: only reads, and the written-back word returns
        exp_fill(32'h010, 5);
        op(1'b0, 32'h013, '0, 5, w);
        wait_drain();
        chk(mem_q.size() == 0, 5, "pending expected beats (write-back mode)",
            32'(mem_q.size()), 32'd0);

        // write-through mode
        do_reset(1'b1);
        exp_fill(32'h080, 7);
        op(1'b0, 32'h081, '0, 7, w);
        // R7: store hit updates the cache and is queued
        exp_beat(1'b1, 32'h081, 32'hD00D_0003, 7);
        op(1'b1, 32'h081, 32'hD00D_0003, 7, w);
        chk(w == 1, 7, "write-through store hit wait cycles", 32'(w), 32'd1);
        op(1'b0, 32'h081, '0, 7, w);
        chk(w == 1, 7, "load after write-through store hits", 32'(w), 32'd1);

        // R6 + R9: store miss, no allocate; following load drains then fills
        lat = 6;
        exp_beat(1'b1, 32'h180, 32'hD00D_0004, 6);
        op(1'b1, 32'h180, 32'hD00D_0004, 6, w);
        exp_fill(32'h180, 9);
        op(1'b0, 32'h180, '0, 9, w);
        chk(mem_q.size() == 0, 6, "beats outstanding after no-allocate miss",
            32'(mem_q.size()), 32'd0);

        // R8 + R10: eight stores fill the FIFO, the ninth waits
        lat = 0;
        hold = 1'b1;
        for (int i = 0; i < 8; i++) begin
            exp_beat(1'b1, 32'h300 + i, 32'hC0DE_0000 + i, 10);
            op(1'b1, 32'h300 + i, 32'hC0DE_0000 + i, 8, w);
            chk(w == 1, 8, "store accepted while FIFO has room", 32'(w), 32'd1);
        end
        exp_beat(1'b1, 32'h308, 32'hC0DE_0008, 10);
        fork
            begin
                repeat (6) @(negedge clk);
                hold = 1'b0;
            end
        join_none
        op(1'b1, 32'h308, 32'hC0DE_0008, 8, w);
        chk(w >= 6, 8, "ninth store stall cycles", 32'(w), 32'd6);
        wait_drain();
        // R10: all nine drained in order
        chk(mem_q.size() == 0, 10, "undrained stores", 32'(mem_q.size()), 32'd0);
        chk(rd_q.size() == 0, 2, "loads never completed", 32'(rd_q.size()), 32'd0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule